// File: doc/BRIEF.md
# LCD Row Scan Timing Generator

This block paces the row scan of a passive-matrix LCD. From a system clock it makes a one-clock line latch pulse at a programmable line period. It also makes a first-line marker that is high for the first line of every frame, and a drive polarity signal that alternates either once per frame or after a programmed number of lines. Alongside these it presents the row address that the common drivers and the display memory fetch should use for the current line.

The number of rows scanned per frame (the duty) is programmable from a small partial-display window up to the full panel height. At the start of every frame the row address is preset from a display-start-line value, so the visible image can be scrolled vertically. The row address then advances by one per line and wraps within the scanned row count. While the enable is low the generator is idle and its outputs rest at zero. Raising the enable starts a fresh frame.

Top module: `lcd_scan_timer`

## Requirements
- R1: While running, `lp_o` is high for exactly one clock per line. Successive `lp_o` pulses are `period_i` clocks apart.
- R2: `row_o`, `flm_o` and `m_o` change only in the clock that directly follows an `lp_o` high clock, which is the falling edge of the latch pulse. In every other clock of a line they hold their values.
- R3: The first line after `en_i` rises is a frame start. That line shows `flm_o` = 1 and `row_o` = `start_i`.
- R4: `flm_o` is high for exactly one line per frame, the first line. Frames are exactly the effective row count long.
- R5: Within a frame `row_o` increments by one per line. After (effective row count − 1) it wraps to 0.
- R6: The effective row count is `duty_i` clamped to the range 10 to 130. A value below 10 scans 10 rows, and a value above 130 scans 130 rows.
- R7: At a frame start, a `start_i` equal to or above the effective row count loads row 0 instead.
- R8: With `nline_i` = 0, `m_o` toggles on every frame-start line and at no other line. The first frame after enable shows `m_o` = 1.
- R9: With `nline_i` = N > 0, `m_o` toggles on every N-th line counted from enable. This count runs across frame boundaries and ignores frame starts.
- R10: While `en_i` is low, within two clocks `lp_o`, `flm_o` and `m_o` are 0 and `row_o` is 0.
- R11: A `period_i` value of 0 or 1 is treated as a line period of 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scan enable; rising starts a new frame |
| period_i | input | PERIOD_W (8) | Clocks per line (minimum 2) |
| duty_i | input | ROW_W (8) | Rows scanned per frame, clamped 10..130 |
| start_i | input | ROW_W (8) | Row address loaded at each frame start |
| nline_i | input | NLINE_W (6) | 0: polarity per frame; N: polarity every N lines |
| lp_o | output | 1 | Line latch pulse, one clock per line |
| flm_o | output | 1 | First-line marker, high for one line per frame |
| m_o | output | 1 | Alternating drive polarity |
| row_o | output | ROW_W (8) | Row address of the current line |

## Verification
The bench builds the block with its default parameters: 130 maximum rows, 10 minimum rows, 8-bit period and 6-bit line-count settings. The duty clamp is therefore reachable at both ends. A duty of 3 gives 10-line frames, and a duty of 200 gives a full 130-line frame, which at a 2-clock period fits in a few hundred cycles. Short line periods keep wrap-around, out-of-range start lines, N-line polarity across frame boundaries and the disable/re-enable restart all within a short run.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/lcd_line_pacer.sv
module lcd_line_pacer #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] len_i,
  output logic                lp_o
);
  logic [PERIOD_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ph_q <= '0;
    else if (!run_i)                        ph_q <= '0;
    else if (ph_q >= len_i - PERIOD_W'(1))  ph_q <= '0;
    else                                    ph_q <= ph_q + PERIOD_W'(1);
  end

  assign lp_o = run_i && (ph_q == '0);

  p_lp_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_o |=> !lp_o);
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [ROW_W-1:0] start_i,
  output logic             frame_start_o,
  output logic             flm_o,
  output logic [ROW_W-1:0] row_o
);
  logic             idle_q, flm_q;
  logic [ROW_W-1:0] li_q, row_q;
  logic [ROW_W-1:0] last_row;

  assign last_row      = rows_i - ROW_W'(1);
  // idle forces the first line after enable to open a frame
  assign frame_start_o = idle_q || (li_q >= last_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      flm_q  <= 1'b0;
      li_q   <= '0;
      row_q  <= '0;
    end else if (!run_i) begin
      idle_q <= 1'b1;
      flm_q  <= 1'b0;
      li_q   <= '0;
      row_q  <= '0;
    end else if (tick_i) begin
      idle_q <= 1'b0;
      if (frame_start_o) begin
        li_q  <= '0;
        flm_q <= 1'b1;
        row_q <= (start_i >= rows_i) ? '0 : start_i;
      end else begin
        li_q  <= li_q + ROW_W'(1);
        flm_q <= 1'b0;
        row_q <= (row_q >= last_row) ? '0 : row_q + ROW_W'(1);
      end
    end
  end

  assign flm_o = flm_q;
  assign row_o = row_q;

  p_start_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frame_start_o && (start_i < rows_i)) |=> (flm_q && row_q == $past(start_i)));

  p_row_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frame_start_o) |=> (row_q == '0 || row_q == $past(row_q) + ROW_W'(1)));
endmodule

// File: rtl/lcd_polarity.sv
module lcd_polarity #(
  parameter int NLINE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               frame_start_i,
  input  logic [NLINE_W-1:0] nline_i,
  output logic               m_o
);
  logic               m_q;
  logic [NLINE_W-1:0] cnt_q;
  logic [NLINE_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + (NLINE_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q   <= 1'b0;
      cnt_q <= '0;
    end else if (!run_i) begin
      m_q   <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (nline_i == '0) begin
        cnt_q <= '0;
        if (frame_start_i) m_q <= ~m_q;
      end else if (cnt_nx >= {1'b0, nline_i}) begin
        cnt_q <= '0;
        m_q   <= ~m_q;
      end else begin
        cnt_q <= cnt_nx[NLINE_W-1:0];
      end
    end
  end

  assign m_o = m_q;

  p_m_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && nline_i == '0) |=> ((m_q != $past(m_q)) == $past(frame_start_i)));
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int MAX_ROWS = 130,
  parameter int MIN_ROWS = 10,
  parameter int PERIOD_W = 8,
  parameter int NLINE_W  = 6,
  localparam int ROW_W   = $clog2(MAX_ROWS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [ROW_W-1:0]    duty_i,
  input  logic [ROW_W-1:0]    start_i,
  input  logic [NLINE_W-1:0]  nline_i,
  output logic                lp_o,
  output logic                flm_o,
  output logic                m_o,
  output logic [ROW_W-1:0]    row_o
);
  import lcd_scan_pkg::*;

  logic                en_q;
  logic [ROW_W-1:0]    rows_eff;
  logic [PERIOD_W-1:0] len_eff;
  logic                frame_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign rows_eff = ROW_W'(clamp_u(int'(duty_i), MIN_ROWS, MAX_ROWS));
  assign len_eff  = (period_i < PERIOD_W'(2)) ? PERIOD_W'(2) : period_i;

  lcd_line_pacer #(.PERIOD_W(PERIOD_W)) i_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q),
    .len_i  (len_eff),
    .lp_o   (lp_o)
  );

  lcd_row_seq #(.ROW_W(ROW_W)) i_rows (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (en_q),
    .tick_i        (lp_o),
    .rows_i        (rows_eff),
    .start_i       (start_i),
    .frame_start_o (frame_start),
    .flm_o         (flm_o),
    .row_o         (row_o)
  );

  lcd_polarity #(.NLINE_W(NLINE_W)) i_pol (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (en_q),
    .tick_i        (lp_o),
    .frame_start_i (frame_start),
    .nline_i       (nline_i),
    .m_o           (m_o)
  );

  p_hold_between_lines_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !lp_o) |=> $stable({row_o, flm_o, m_o}));

  p_flm_one_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_o && flm_o) |=> !flm_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (!flm_o && !m_o && row_o == '0));
endmodule

// File: tb/test_lcd_scan_timer.sv
module test_lcd_scan_timer;
  localparam int ROW_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [7:0]       period_i = 8'd4;
  logic [ROW_W-1:0] duty_i = 8'd12;
  logic [ROW_W-1:0] start_i = '0;
  logic [5:0]       nline_i = '0;
  logic             lp_o, flm_o, m_o;
  logic [ROW_W-1:0] row_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  lcd_scan_timer i_lcd_scan_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
    .duty_i(duty_i), .start_i(start_i), .nline_i(nline_i),
    .lp_o(lp_o), .flm_o(flm_o), .m_o(m_o), .row_o(row_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for the next latch pulse, returns its distance from the previous one
  // and the outputs shown once the pulse has fallen
  task automatic line(output int per, output int r, output int f, output int mm);
    per = 0;
    do begin @(negedge clk_i); per++; end while (!lp_o && per < 2000);
    per = per + 1;
    @(negedge clk_i);
    r = row_o; f = flm_o; mm = m_o;
  endtask

  task automatic stop_scan();
    @(negedge clk_i); en_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(lp_o == 0 && flm_o == 0, "R10 reset lp/flm", {lp_o, flm_o}, 0);
    check(m_o == 0 && row_o == 0, "R10 reset m/row", {m_o, row_o}, 0);
  endtask

  task automatic t_basic();
    int per, r, f, mm;
    @(negedge clk_i);
    duty_i = 12; start_i = 3; period_i = 4; nline_i = 0; en_i = 1;
    line(per, r, f, mm);
    check(lp_o == 0, "R1 lp one clock", lp_o, 0);
    check(f == 1 && r == 3, "R3 first line flm/row", r, 3);
    check(mm == 1, "R8 first frame m", mm, 1);
    for (int k = 1; k < 12; k++) begin
      line(per, r, f, mm);
      check(per == 4, "R1 line period", per, 4);
      check(r == (3 + k) % 12, "R5 row step/wrap", r, (3 + k) % 12);
      check(f == 0, "R4 flm only first line", f, 0);
      check(mm == 1, "R8 m steady in frame", mm, 1);
    end
    line(per, r, f, mm);
    check(f == 1 && r == 3, "R4 next frame after 12 lines", r, 3);
    check(mm == 0, "R8 m toggles at frame", mm, 0);
    @(negedge clk_i);
    check(row_o == 3 && flm_o == 1 && m_o == 0 && lp_o == 0, "R2 hold within line", row_o, 3);
    @(negedge clk_i);
    check(row_o == 3 && flm_o == 1 && m_o == 0, "R2 hold within line", row_o, 3);
    stop_scan();
  endtask

  task automatic frame_len(input int duty, output int len);
    int per, r, f, mm;
    @(negedge clk_i);
    duty_i = duty; start_i = 0; period_i = 2; nline_i = 0; en_i = 1;
    line(per, r, f, mm);
    len = 0;
    do begin line(per, r, f, mm); len++; end while (f == 0 && len < 400);
    stop_scan();
  endtask

  task automatic t_duty_clamp();
    int len;
    frame_len(3, len);
    check(len == 10, "R6 duty below min", len, 10);
    frame_len(200, len);
    check(len == 130, "R6 duty above max", len, 130);
    frame_len(37, len);
    check(len == 37, "R6 duty in range", len, 37);
  endtask

  task automatic t_start();
    int per, r, f, mm;
    @(negedge clk_i);
    duty_i = 12; start_i = 20; period_i = 3; nline_i = 0; en_i = 1;
    line(per, r, f, mm);
    check(f == 1 && r == 0, "R7 start out of range", r, 0);
    stop_scan();
    start_i = 12;
    en_i = 1;
    line(per, r, f, mm);
    check(f == 1 && r == 0, "R7 start equal to rows", r, 0);
    stop_scan();
    start_i = 11;
    en_i = 1;
    line(per, r, f, mm);
    check(f == 1 && r == 11, "R7 start at last row", r, 11);
    line(per, r, f, mm);
    check(r == 0 && f == 0, "R5 wrap from last row", r, 0);
    stop_scan();
  endtask

  task automatic t_nline();
    int per, r, f, mm;
    @(negedge clk_i);
    duty_i = 10; start_i = 0; period_i = 2; nline_i = 3; en_i = 1;
    for (int k = 1; k <= 25; k++) begin
      line(per, r, f, mm);
      check(mm == (k / 3) % 2, "R9 m every 3 lines", mm, (k / 3) % 2);
    end
    stop_scan();
    nline_i = 1;
    en_i = 1;
    for (int k = 1; k <= 4; k++) begin
      line(per, r, f, mm);
      check(mm == k % 2, "R9 m every line", mm, k % 2);
    end
    stop_scan();
  endtask

  task automatic t_period_clamp();
    int per, r, f, mm;
    @(negedge clk_i);
    duty_i = 12; start_i = 0; period_i = 0; nline_i = 0; en_i = 1;
    line(per, r, f, mm);
    line(per, r, f, mm);
    check(per == 2, "R11 period 0", per, 2);
    period_i = 1;
    line(per, r, f, mm);
    line(per, r, f, mm);
    check(per == 2, "R11 period 1", per, 2);
    period_i = 7;
    line(per, r, f, mm);
    line(per, r, f, mm);
    check(per == 7, "R1 period 7", per, 7);
    stop_scan();
  endtask

  task automatic t_disable();
    int per, r, f, mm;
    @(negedge clk_i);
    duty_i = 12; start_i = 2; period_i = 3; nline_i = 0; en_i = 1;
    for (int k = 0; k < 5; k++) line(per, r, f, mm);
    en_i = 0;
    repeat (2) @(negedge clk_i);
    check(lp_o == 0 && flm_o == 0, "R10 disabled lp/flm", {lp_o, flm_o}, 0);
    check(m_o == 0 && row_o == 0, "R10 disabled m/row", row_o, 0);
    repeat (5) @(negedge clk_i);
    check(lp_o == 0, "R10 no lp while disabled", lp_o, 0);
    start_i = 5;
    en_i = 1;
    line(per, r, f, mm);
    check(f == 1 && r == 5 && mm == 1, "R3 restart frame", r, 5);
    stop_scan();
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_duty_clamp();
    t_start();
    t_nline();
    t_period_clamp();
    t_disable();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule